// File: doc/BRIEF.md
# Watchdog and Countdown Timer

An 8-bit down-counter that software sets up either as a watchdog or as a repeating countdown timer. The counter advances only on a tick enable, chosen from four tick inputs that the surrounding chip derives from its system clock (fast, 64 Hz, 1 Hz and one-per-minute rates in the intended use). Software writes a mode, a tick source and a pulse/level choice through a configuration strobe. It loads the start value through a value strobe. It reads and clears the flags through a small status port.

In countdown mode the counter sets its flag each time it expires and then restarts from the loaded value. In either watchdog mode an expiry sets a watchdog flag and the counter stops. Software cannot clear that flag by writing it. Only loading a new value or reading the status clears it. One watchdog mode also raises a reset request. The countdown interrupt can be a level that follows the flag, or a short pulse. Clearing the flag ends the pulse at once.

Top module: `wdt_timer`

## Requirements
- R1: After reset both flags, `irq` and `rst_req` are low and the mode is off.
- R2: In countdown mode (`cfg_mode` = 11), loading n (n > 0) sets the countdown flag (`stat_q[0]`) on the n-th selected tick. The count then reloads n, so the next expiry falls n ticks later.
- R3: `cfg_src` code i selects `tick_en[i]`. Ticks on the other three inputs do not move the counter.
- R4: A loaded value of 0 never expires, whatever the number of ticks.
- R5: A status write with `stat_wdata[0]` = 0 clears the countdown flag. A write with `stat_wdata[0]` = 1 leaves it unchanged.
- R6: The watchdog flag (`stat_q[1]`) ignores status writes of either value. It clears on a value load, or on the clock edge that ends a `stat_rd` strobe. During the strobe `stat_q` still shows the flag.
- R7: In watchdog interrupt mode (`cfg_mode` = 01), an expiry after n ticks sets the watchdog flag and raises `irq`, while `rst_req` stays low.
- R8: In watchdog reset mode (`cfg_mode` = 10), an expiry raises both `irq` and `rst_req`. Both drop once the flag is cleared.
- R9: In countdown level mode (`cfg_pulse` = 0), `irq` equals the countdown flag for as long as the flag is set.
- R10: In countdown pulse mode (`cfg_pulse` = 1), `irq` is high for PULSE_CYC clock cycles after an expiry. If the flag is cleared earlier, `irq` drops on the clock edge that clears it.
- R11: With the mode off (`cfg_mode` = 00), ticks set no flag and `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 4 | Tick enables, one per source code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | 00 off, 01 watchdog irq, 10 watchdog irq+reset, 11 countdown |
| cfg_src | input | 2 | Tick source select |
| cfg_pulse | input | 1 | 1 pulsed countdown interrupt, 0 level |
| val_we | input | 1 | Value load strobe |
| val_data | input | W | Start/reload value |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Status write data (bit0 countdown, bit1 ignored) |
| stat_rd | input | 1 | Status read strobe |
| stat_q | output | 2 | {watchdog flag, countdown flag} |
| irq | output | 1 | Interrupt output |
| rst_req | output | 1 | Reset request output |

## Verification
The assertions assume that software does not clear the countdown flag in the same cycle as an expiry. They also assume that a value load does not coincide with a status read that is expected to leave the flag untouched. The bench issues every register access on its own cycle, between tick pulses, so neither overlap occurs. Tick enables are single-cycle pulses on one input at a time, which matches the one-event-per-edge view the properties take.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int W         = 8,
  parameter int PULSE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   tick_en,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_mode,
  input  logic [1:0]   cfg_src,
  input  logic         cfg_pulse,
  input  logic         val_we,
  input  logic [W-1:0] val_data,
  input  logic         stat_we,
  input  logic [1:0]   stat_wdata,
  input  logic         stat_rd,
  output logic [1:0]   stat_q,
  output logic         irq,
  output logic         rst_req
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [1:0] M_OFF = 2'b00, M_WRST = 2'b10, M_CD = 2'b11;

  logic [1:0]   mode_q, src_q;
  logic         pulse_q, cd_flag, wd_flag;
  logic [W-1:0] reload_q, cnt_q;
  logic [PW-1:0] pcnt_q;

  wire tick   = tick_en[src_q];
  wire step   = tick && (mode_q != M_OFF) && (cnt_q != '0) && !val_we;
  wire expire = step && (cnt_q == W'(1));
  wire cd_set = expire && (mode_q == M_CD);
  wire wd_set = expire && (mode_q != M_CD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_OFF;
      src_q    <= '0;
      pulse_q  <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (cfg_we) begin
        mode_q  <= cfg_mode;
        src_q   <= cfg_src;
        pulse_q <= cfg_pulse;
      end
      if (val_we) begin
        reload_q <= val_data;
        cnt_q    <= val_data;
      end else if (expire) begin
        cnt_q <= (mode_q == M_CD) ? reload_q : '0;
      end else if (step) begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_flag <= 1'b0;
      wd_flag <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      if (cd_set)                          cd_flag <= 1'b1;
      else if (stat_we && !stat_wdata[0])  cd_flag <= 1'b0;
      if (wd_set)                          wd_flag <= 1'b1;
      else if (val_we || stat_rd)          wd_flag <= 1'b0;
      if (cd_set)                          pcnt_q <= PW'(PULSE_CYC);
      else if (pcnt_q != '0)               pcnt_q <= pcnt_q - PW'(1);
    end
  end

  wire cd_irq = pulse_q ? (cd_flag && (pcnt_q != '0)) : cd_flag;

  assign stat_q  = {wd_flag, cd_flag};
  assign irq     = (mode_q == M_CD) ? cd_irq : ((mode_q != M_OFF) && wd_flag);
  assign rst_req = (mode_q == M_WRST) && wd_flag;
endmodule

module wdt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic       cd_flag,
  input logic       wd_flag,
  input logic       irq,
  input logic       rst_req,
  input logic       val_we,
  input logic       stat_we,
  input logic [1:0] stat_wdata,
  input logic       stat_rd
);
  AST_WD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wd_flag && stat_we && !stat_rd && !val_we |=> wd_flag); // R6
  AST_LOAD_CLEARS_WD: assert property (@(posedge clk) disable iff (!rst_n)
    val_we |=> !wd_flag); // R6
  AST_CD_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    cd_flag && stat_we && stat_wdata[0] |=> cd_flag); // R5
  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq); // R8
  AST_CD_ONLY_IN_CD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd_flag) |-> $past(mode_q) == 2'b11); // R2
  AST_CLEAR_CUTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_flag) && mode_q == 2'b11 |-> !irq); // R10
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_q) == 2'b00 |-> !$rose(cd_flag) && !$rose(wd_flag)); // R11
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cd_flag(cd_flag),
  .wd_flag(wd_flag), .irq(irq), .rst_req(rst_req), .val_we(val_we),
  .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rd(stat_rd)
);

// File: tb/sim_wdt_timer.sv
module sim_wdt_timer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] tick_en = '0;
  logic       cfg_we = 0, cfg_pulse = 0, val_we = 0, stat_we = 0, stat_rd = 0;
  logic [1:0] cfg_mode = '0, cfg_src = '0, stat_wdata = '0;
  logic [7:0] val_data = '0;
  logic [1:0] stat_q;
  logic       irq, rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  wdt_timer #(.W(8), .PULSE_CYC(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_src(cfg_src), .cfg_pulse(cfg_pulse),
    .val_we(val_we), .val_data(val_data), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .stat_rd(stat_rd), .stat_q(stat_q),
    .irq(irq), .rst_req(rst_req));

  always #10 clk = ~clk;

  // {src, n, ticks, expected countdown flag}
  localparam logic [18:0] VEC [8] = '{
    {2'd0, 8'd3, 8'd2, 1'b0}, {2'd0, 8'd3, 8'd3, 1'b1},
    {2'd1, 8'd1, 8'd1, 1'b1}, {2'd2, 8'd5, 8'd4, 1'b0},
    {2'd3, 8'd5, 8'd5, 1'b1}, {2'd1, 8'd0, 8'd10, 1'b0},
    {2'd2, 8'd2, 8'd4, 1'b1}, {2'd3, 8'd200, 8'd199, 1'b0}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick(logic [1:0] s);
    @(negedge clk) tick_en = 4'b1 << s;
    @(negedge clk) tick_en = '0;
  endtask

  task automatic wr_cfg(logic [1:0] m, logic [1:0] s, logic p);
    @(negedge clk) begin cfg_we = 1; cfg_mode = m; cfg_src = s; cfg_pulse = p; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic load(logic [7:0] n);
    @(negedge clk) begin val_we = 1; val_data = n; end
    @(negedge clk) val_we = 0;
  endtask

  task automatic stat_wr(logic [1:0] d);
    @(negedge clk) begin stat_we = 1; stat_wdata = d; end
    @(negedge clk) stat_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 flags", {6'd0, stat_q}, 8'd0);
    chk("R1 outputs", {6'd0, irq, rst_req}, 8'd0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      logic [1:0] s; logic [7:0] n, k; logic e;
      {s, n, k, e} = VEC[i];
      wr_cfg(2'b11, s, 1'b0);
      stat_wr(2'b00);
      load(n);
      for (int j = 0; j < k; j++) begin
        do_tick(s);
        do_tick(s + 2'd1);
      end
      chk(n == 0 ? "R4 zero value" : "R2/R3 countdown", {7'd0, stat_q[0]}, {7'd0, e});
    end

    // R2 reload period
    wr_cfg(2'b11, 2'd0, 1'b0); stat_wr(2'b00); load(8'd3);
    repeat (3) do_tick(2'd0);
    chk("R2 first expiry", {7'd0, stat_q[0]}, 8'd1);
    stat_wr(2'b00);
    repeat (2) do_tick(2'd0);
    chk("R2 reload before", {7'd0, stat_q[0]}, 8'd0);
    do_tick(2'd0);
    chk("R2 reload expiry", {7'd0, stat_q[0]}, 8'd1);
    // R5 write one keeps, R9 level
    stat_wr(2'b01);
    chk("R5 write one keeps", {7'd0, stat_q[0]}, 8'd1);
    repeat (10) @(negedge clk);
    chk("R9 level held", {7'd0, irq}, 8'd1);
    stat_wr(2'b10);
    chk("R5 write zero clears", {7'd0, stat_q[0]}, 8'd0);
    chk("R9 level follows", {7'd0, irq}, 8'd0);

    // R10 pulse length
    wr_cfg(2'b11, 2'd0, 1'b1); load(8'd1);
    do_tick(2'd0);
    chk("R10 pulse start", {7'd0, irq}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R10 pulse last", {7'd0, irq}, 8'd1);
    @(negedge clk);
    chk("R10 pulse end", {7'd0, irq}, 8'd0);
    chk("R10 flag stays", {7'd0, stat_q[0]}, 8'd1);
    stat_wr(2'b00);
    do_tick(2'd0);
    stat_wr(2'b00);
    chk("R10 pulse cut", {7'd0, irq}, 8'd0);

    // R7 watchdog interrupt
    wr_cfg(2'b01, 2'd1, 1'b0); load(8'd2);
    repeat (2) do_tick(2'd1);
    chk("R7 wd flag", {6'd0, stat_q}, 8'd2);
    chk("R7 irq no reset", {6'd0, irq, rst_req}, 8'd2);
    stat_wr(2'b00);
    stat_wr(2'b10);
    chk("R6 write ignored", {7'd0, stat_q[1]}, 8'd1);
    @(negedge clk) stat_rd = 1;
    #1 chk("R6 read shows flag", {7'd0, stat_q[1]}, 8'd1);
    @(negedge clk) stat_rd = 0;
    chk("R6 read clears", {7'd0, stat_q[1]}, 8'd0);
    chk("R7 irq drops", {7'd0, irq}, 8'd0);

    // R8 watchdog reset
    wr_cfg(2'b10, 2'd2, 1'b0); load(8'd1);
    do_tick(2'd2);
    chk("R8 irq+reset", {6'd0, irq, rst_req}, 8'd3);
    load(8'd5);
    chk("R8 load clears", {5'd0, stat_q[1], irq, rst_req}, 8'd0);

    // R11 off
    wr_cfg(2'b00, 2'd0, 1'b0); load(8'd1);
    repeat (3) do_tick(2'd0);
    chk("R11 off", {5'd0, stat_q, irq}, 8'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule